// File: doc/BRIEF.md
# Table-Driven Programmable State Machine

This block is a small finite state machine whose transitions are not fixed in logic but read from a writable table. The table is addressed by the current 3-bit state joined with a 3-bit input symbol, and the entry found there becomes the next state. A second table gives an 8-bit output word for each state. The output register is loaded from that table, so the outputs always show the decode of the state held one clock earlier.

The machine never advances on its own. A state change is committed only on the rising edge of an update trigger. The selector inputs are sampled in that same cycle. A trigger held high for many cycles still causes exactly one transition.

Software fills both tables through a simple address/data/write-enable port while the machine is held in its synchronous clear. Writes made at any other time are dropped. This stops a running machine from having its tables changed under it.

Top module: `table_fsm`

## Requirements
- R1: While the asynchronous active-low reset `rst_n` is low, `state_o` is 0, `out_o` is 0 and every entry of both tables is 0.
- R2: When `clr_i` is high at a clock edge, `state_o` is 0 after that edge, whatever `trig_i` and `sel_i` are doing.
- R3: With `clr_i` low, and no trigger rising edge at a clock edge, `state_o` keeps its value across that edge for any value of `sel_i`.
- R4: A trigger rising edge at a clock edge is `trig_i` high at that edge after being low at the previous edge. At such an edge, with `clr_i` low, `state_o` becomes the next-state entry at address `state_o*8 + sel_i`, where `sel_i` is sampled at the same edge. Holding `trig_i` high gives only one transition.
- R5: After every clock edge, `out_o` equals the output-table entry of the value that `state_o` had before that edge. The output therefore lags the state by one cycle.
- R6: A write happens only when `wr_en_i` and `clr_i` are both high at a clock edge. When `wr_addr_i[6]` is 0, next-state entry `wr_addr_i[5:0]` takes `wr_data_i[2:0]`. When `wr_addr_i[6]` is 1, output entry `wr_addr_i[2:0]` takes `wr_data_i`, and `wr_addr_i[5:3]` is ignored. A write attempted while `clr_i` is low has no effect on either table.
- R7: The trigger history register keeps sampling while `clr_i` is high. A trigger that rises during clear and is still high when clear drops causes no transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear; state forced to 0, table writes enabled |
| trig_i | input | 1 | Update trigger; its rising edge commits one transition |
| sel_i | input | 3 | Encoded input symbol for the next-state lookup |
| wr_en_i | input | 1 | Table write enable |
| wr_addr_i | input | 7 | Table write address; bit 6 chooses the table |
| wr_data_i | input | 8 | Table write data |
| state_o | output | 3 | Current state |
| out_o | output | 8 | Registered output decode of the previous state |

## Verification
The bench holds the trigger high for several cycles while `sel_i` keeps changing. A design that acts on the trigger level, rather than its edge, would walk through several states here. The bench also writes both tables while the machine is running; a design that fails to gate those writes would take transitions from the corrupted entries. Other stimulus raises the trigger in the same cycle as clear and keeps it high past the release of clear. A design that gives the trigger priority over clear, or that freezes the trigger history during clear, would leave state 0 in these cases. Finally, trigger pulses on alternating cycles with a new selector each time catch a design that samples `sel_i` one cycle late or that updates the output in step with the state instead of one cycle after it.

// File: rtl/table_fsm_pkg.sv
package table_fsm_pkg;
  localparam int unsigned ST_W  = 3;
  localparam int unsigned SYM_W = 3;
  localparam int unsigned OUT_W = 8;
endpackage

// File: rtl/tfsm_trig_edge.sv
module tfsm_trig_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic pulse_o
);
  logic trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_i;
  end

  assign pulse_o = trig_i & ~trig_q;

  // A held trigger must never give two pulses in a row (R4)
  assert_single_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/tfsm_table.sv
module tfsm_table #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DEPTH-1:0][DW-1:0] mem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mem_q <= '0;
    else if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

  // Contents change only through an enabled write (R6)
  assert_table_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(mem_q));
endmodule

// File: rtl/table_fsm.sv
module table_fsm
  import table_fsm_pkg::*;
#(
  parameter int unsigned STATE_W = ST_W,
  parameter int unsigned SEL_W   = SYM_W,
  parameter int unsigned DOUT_W  = OUT_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_i,
  input  logic                      trig_i,
  input  logic [SEL_W-1:0]          sel_i,
  input  logic                      wr_en_i,
  input  logic [STATE_W+SEL_W:0]    wr_addr_i,
  input  logic [DOUT_W-1:0]         wr_data_i,
  output logic [STATE_W-1:0]        state_o,
  output logic [DOUT_W-1:0]         out_o
);
  localparam int unsigned NS_AW = STATE_W + SEL_W;

  logic                 pulse;
  logic                 ns_we, ot_we;
  logic [STATE_W-1:0]   ns_rd;
  logic [DOUT_W-1:0]    ot_rd;
  logic [STATE_W-1:0]   state_q, state_d;
  logic [DOUT_W-1:0]    out_q;

  assign ns_we = wr_en_i & clr_i & ~wr_addr_i[NS_AW];
  assign ot_we = wr_en_i & clr_i &  wr_addr_i[NS_AW];

  tfsm_trig_edge i_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_i  (trig_i),
    .pulse_o (pulse)
  );

  tfsm_table #(.AW(NS_AW), .DW(STATE_W)) i_ns_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (ns_we),
    .waddr_i (wr_addr_i[NS_AW-1:0]),
    .wdata_i (wr_data_i[STATE_W-1:0]),
    .raddr_i ({state_q, sel_i}),
    .rdata_o (ns_rd)
  );

  tfsm_table #(.AW(STATE_W), .DW(DOUT_W)) i_out_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (ot_we),
    .waddr_i (wr_addr_i[STATE_W-1:0]),
    .wdata_i (wr_data_i),
    .raddr_i (state_q),
    .rdata_o (ot_rd)
  );

  always_comb begin
    state_d = state_q;
    if (clr_i)      state_d = '0;
    else if (pulse) state_d = ns_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      out_q   <= '0;
    end else begin
      state_q <= state_d;
      out_q   <= ot_rd;
    end
  end

  assign state_o = state_q;
  assign out_o   = out_q;

  assert_clear_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (state_o == '0));

  assert_hold_without_trigger_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !pulse) |=> $stable(state_o));
endmodule

// File: tb/test_table_fsm.sv
module test_table_fsm;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, clr, trig, wr_en;
  logic [2:0] sel;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;
  logic [2:0] state;
  logic [7:0] dout;

  int errors = 0, checks = 0;
  string tag = "R1";

  int ns_m[64];
  int ot_m[8];
  int m_state = 0, m_out = 0, m_trq = 0;

  always #(PERIOD/2) clk = ~clk;

  table_fsm i_table_fsm (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .trig_i(trig), .sel_i(sel),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .state_o(state), .out_o(dout)
  );

  // behavioural reference, advanced on each clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_out = 0; m_trq = 0;
      for (int i = 0; i < 64; i++) ns_m[i] = 0;
      for (int i = 0; i < 8; i++)  ot_m[i] = 0;
    end else begin
      int nxt_out;
      bit edge_seen;
      nxt_out   = ot_m[m_state];
      edge_seen = trig && (m_trq == 0);
      if (clr) begin
        if (wr_en) begin
          if (wr_addr[6]) ot_m[wr_addr[2:0]] = wr_data;
          else            ns_m[wr_addr[5:0]] = wr_data[2:0];
        end
        m_state = 0;
      end else if (edge_seen) begin
        m_state = ns_m[m_state*8 + sel];
      end
      m_out = nxt_out;
      m_trq = trig;
    end
  end

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(tag, "state", state, m_state);
      check(tag, "out", dout, m_out);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(PERIOD*200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 0; clr = 0; trig = 0; sel = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    cyc(3);
    check("R1", "reset state", state, 0);
    check("R1", "reset out", dout, 0);
    rst_n = 1;
    // R6: load tables while in clear
    tag = "R6"; clr = 1;
    for (int a = 0; a < 64; a++) begin
      wr_en = 1; wr_addr = 7'(a); wr_data = 8'((a*5 + 3) % 8); cyc(1);
    end
    for (int s = 0; s < 8; s++) begin
      wr_en = 1; wr_addr = 7'(64 + s + 8*(s % 2)); wr_data = 8'((8'h3C ^ (s*37)) & 255); cyc(1);
    end
    wr_en = 0; cyc(1); clr = 0; cyc(2);
    // R4/R5: single pulses with various symbols
    tag = "R4";
    for (int i = 0; i < 10; i++) begin
      sel = 3'(i*3); trig = 1; cyc(1); trig = 0; cyc(1);
    end
    // R3: symbols change without trigger
    tag = "R3";
    for (int i = 0; i < 8; i++) begin sel = 3'(i); cyc(1); end
    // R4: held trigger, symbol changing
    tag = "R4";
    trig = 1;
    for (int i = 0; i < 6; i++) begin sel = 3'(7 - i); cyc(1); end
    trig = 0; cyc(2);
    // R6: writes while running must be dropped
    tag = "R6";
    for (int i = 0; i < 16; i++) begin
      wr_en = 1; wr_addr = 7'(i*9); wr_data = 8'(255 - i*7); cyc(1);
    end
    wr_en = 0;
    for (int i = 0; i < 8; i++) begin
      sel = 3'(i); trig = 1; cyc(1); trig = 0; cyc(1);
    end
    // R2/R7: trigger rising together with clear, held past release
    tag = "R7";
    sel = 3'd2; trig = 1; clr = 1; cyc(2); clr = 0; cyc(3); trig = 0; cyc(1);
    tag = "R2";
    trig = 1; sel = 3'd6; cyc(1); trig = 0; cyc(1); clr = 1; trig = 1; cyc(1);
    clr = 0; trig = 0; cyc(2);
    // R5: back-to-back pulses, output lags state
    tag = "R5";
    for (int i = 0; i < 12; i++) begin
      sel = 3'(i*5); trig = (i % 2 == 0); cyc(1);
    end
    trig = 0; cyc(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule